// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps every row of a 1024-row asynchronous DRAM refreshed and brings the device up after power-on. After reset it owns the strobe pins. It holds them idle for a long power-up pause, then runs a fixed number of refresh cycles back to back. Only then does it raise `initDone`, which tells the access controller that ordinary traffic may begin.

In normal operation an interval timer adds one refresh request per period. Requests that have not been served stay pending, and a saturating counter queues up to `MAX_PENDING` of them. `refReq` tells the access controller that work is pending. When the controller answers with `refGnt`, the block takes the pins (`driveEn` high) and runs refresh cycles back to back while the grant stays up and requests remain. It gives the pins back once a precharge completes with no grant or no request left. The default refresh style places the CAS strobe first and keeps the write strobe high throughout, so the device can never enter a special test mode by accident. A parameter selects a row-addressed style instead. In that style CAS stays high and an internal row counter is driven on the address pins.

All timing is expressed as whole clock cycles through parameters. The defaults suit a 20 ns clock: a 200 µs pause, a 15.6 µs refresh period, one setup cycle, three active cycles and two precharge cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and right after its release, `rasN`, `casN` and `weN` are high, `driveEn` is high, and `initDone` and `refReq` are low. The first strobe edge of the first refresh cycle appears exactly `INIT_WAIT` rising clock edges after reset is released.
- R2: Before `initDone`, the block keeps `driveEn` high and runs exactly `INIT_CYCLES` refresh cycles back to back, whatever the value of `refGnt`.
- R3: `initDone` rises on the same edge as `driveEn` falls. That edge comes exactly `T_PRE` cycles after `rasN` rises at the end of the last initialization cycle.
- R4: In the default (CAS-first) style, `casN` is low for exactly `T_SETUP` cycles before `rasN` falls. It stays low for as long as `rasN` is low, and both rise on the same edge.
- R5: Every refresh cycle holds `rasN` low for exactly `T_ACTIVE` cycles. Inside a back-to-back burst, `rasN` stays high for exactly `T_PRE` cycles before the next cycle's first strobe edge, and never for fewer than `T_PRE` cycles anywhere.
- R6: `weN` is high at all times.
- R7: Once `initDone` is high, a request is added every `REF_INTERVAL` cycles, with the first one added `REF_INTERVAL` cycles after `initDone` rises. After initialization, `refReq` is high exactly when at least one request is pending.
- R8: At most `MAX_PENDING` requests are pending; a request added while the queue is full is lost. A request added on the same edge that a cycle consumes one leaves the count unchanged. A full queue drains as exactly `MAX_PENDING` cycles.
- R9: After initialization, a refresh cycle starts only on an edge where `refGnt` is high and a request is pending, and each start consumes one request. When the block is idle, or at the end of a precharge, a high grant with a pending request always starts the next cycle.
- R10: After initialization, `driveEn` is high from the first strobe edge of a burst until the precharge of its last cycle has ended. While `driveEn` is low, `rasN` and `casN` are high.
- R11: With `RAS_ONLY` set, `casN` stays high. `rowAddr` carries the row counter, which starts at 0. It is stable from the setup cycle through the whole `rasN` low time, advances by one per refresh cycle, and wraps from 1023 to 0.
- R12: In the default style, `rowAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGnt | input | 1 | Grant from the access controller |
| refReq | output | 1 | At least one refresh pending (after initialization) |
| driveEn | output | 1 | Block owns the DRAM strobe and address pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write strobe, held high |
| rowAddr | output | ROW_W | Row address for the row-addressed style |
| initDone | output | 1 | Power-up sequence finished |

## Verification
The hardest situation to reach is a full request queue, particularly a timer tick that lands on the same edge a cycle consumes a request. The bench withholds the grant for several periods to fill the queue. It then waits for a tick and opens the grant for a window shorter than one period, so the drained count must equal the queue depth. Long stretches of randomly toggled grant make ticks collide with cycle starts and precharge ends. A per-edge model of the pending count checks `refReq` and every start decision. Wrapping the row counter needs more than 1024 cycles, so a second, row-addressed instance runs with a short period and a permanent grant alongside the main one.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRE
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic loadSetup;
    logic loadActive;
    logic loadPre;
    logic consume;
    logic initStep;
    logic rowAdvance;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone;
    logic havePending;
    logic lastInit;
  } dpStatus_t;

endpackage

// File: rtl/dram_refresh_dp.sv
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int INIT_WAIT    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int MAX_PENDING  = 4,
  parameter int T_SETUP      = 1,
  parameter int T_ACTIVE     = 3,
  parameter int T_PRE        = 2,
  parameter int ROW_W        = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initDone,
  input  ctrlStrobes_t     strb,
  output dpStatus_t        status,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int PH_A   = (T_SETUP > T_ACTIVE) ? T_SETUP : T_ACTIVE;
  localparam int PH_B   = (PH_A > T_PRE) ? PH_A : T_PRE;
  localparam int PH_MAX = (INIT_WAIT > PH_B) ? INIT_WAIT : PH_B;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TMR_W  = $clog2(REF_INTERVAL + 1);
  localparam int PEND_W = $clog2(MAX_PENDING + 1);
  localparam int ICNT_W = $clog2(INIT_CYCLES + 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [TMR_W-1:0]  tmr;
  logic [PEND_W-1:0] pend;
  logic [ICNT_W-1:0] initCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic              tick;

  // one down-counter times the power-up pause and every cycle phase
  always_ff @(posedge clk) begin
    if (!rstN)                 phaseCnt <= PH_W'(INIT_WAIT - 1);
    else if (strb.loadSetup)   phaseCnt <= PH_W'(T_SETUP - 1);
    else if (strb.loadActive)  phaseCnt <= PH_W'(T_ACTIVE - 1);
    else if (strb.loadPre)     phaseCnt <= PH_W'(T_PRE - 1);
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  // refresh period timer, free-running once initialization is over
  assign tick = initDone && (tmr == TMR_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN)          tmr <= '0;
    else if (tick)      tmr <= '0;
    else if (initDone)  tmr <= tmr + 1'b1;
  end

  // saturating queue of outstanding requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else if (tick && !strb.consume) begin
      if (pend != PEND_W'(MAX_PENDING)) pend <= pend + 1'b1;
    end else if (!tick && strb.consume) begin
      pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      initCnt <= '0;
    else if (strb.initStep && initCnt != ICNT_W'(INIT_CYCLES))
      initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rowCnt <= '0;
    else if (strb.rowAdvance) rowCnt <= rowCnt + 1'b1;
  end

  assign rowAddr            = rowCnt;
  assign status.phaseDone   = (phaseCnt == '0);
  assign status.havePending = (pend != '0);
  assign status.lastInit    = (initCnt == ICNT_W'(INIT_CYCLES));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refGnt,
  input  dpStatus_t    status,
  output ctrlStrobes_t strb,
  output logic         initDone,
  output logic         rasN,
  output logic         casN,
  output logic         driveEn
);

  seqState_e state, nextState;
  logic      enterSetup;
  logic      casNext;
  logic      initDoneNext;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_WAIT:   if (status.phaseDone) nextState = ST_SETUP;
      ST_IDLE:   if (refGnt && status.havePending) nextState = ST_SETUP;
      ST_SETUP:  if (status.phaseDone) nextState = ST_ACTIVE;
      ST_ACTIVE: if (status.phaseDone) nextState = ST_PRE;
      ST_PRE: begin
        if (status.phaseDone) begin
          if (!initDone)
            nextState = status.lastInit ? ST_IDLE : ST_SETUP;
          else
            nextState = (refGnt && status.havePending) ? ST_SETUP : ST_IDLE;
        end
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  assign enterSetup      = (nextState == ST_SETUP) && (state != ST_SETUP);
  assign strb.loadSetup  = enterSetup;
  assign strb.consume    = enterSetup && initDone;
  assign strb.initStep   = enterSetup && !initDone;
  assign strb.loadActive = (state == ST_SETUP) && (nextState == ST_ACTIVE);
  assign strb.loadPre    = (state == ST_ACTIVE) && (nextState == ST_PRE);
  assign strb.rowAdvance = strb.loadPre && RAS_ONLY;

  assign initDoneNext = initDone || ((state == ST_PRE) && (nextState == ST_IDLE));

  generate
    if (RAS_ONLY) begin : gRowOnly
      assign casNext = 1'b1;
    end else begin : gCasFirst
      assign casNext = !((nextState == ST_SETUP) || (nextState == ST_ACTIVE));
    end
  endgenerate

  // pins are registered straight from the next state so they are glitch-free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      initDone <= 1'b0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      driveEn  <= 1'b1;
    end else begin
      state    <= nextState;
      initDone <= initDoneNext;
      rasN     <= (nextState != ST_ACTIVE);
      casN     <= casNext;
      driveEn  <= (nextState != ST_IDLE);
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int INIT_WAIT    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int MAX_PENDING  = 4,
  parameter int T_SETUP      = 1,
  parameter int T_ACTIVE     = 3,
  parameter int T_PRE        = 2,
  parameter int ROW_W        = 10,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGnt,
  output logic             refReq,
  output logic             driveEn,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] rowAddr,
  output logic             initDone
);

  ctrlStrobes_t strb;
  dpStatus_t    status;

  dram_refresh_ctrl #(
    .RAS_ONLY(RAS_ONLY)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGnt   (refGnt),
    .status   (status),
    .strb     (strb),
    .initDone (initDone),
    .rasN     (rasN),
    .casN     (casN),
    .driveEn  (driveEn)
  );

  dram_refresh_dp #(
    .INIT_WAIT    (INIT_WAIT),
    .INIT_CYCLES  (INIT_CYCLES),
    .REF_INTERVAL (REF_INTERVAL),
    .MAX_PENDING  (MAX_PENDING),
    .T_SETUP      (T_SETUP),
    .T_ACTIVE     (T_ACTIVE),
    .T_PRE        (T_PRE),
    .ROW_W        (ROW_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .initDone (initDone),
    .strb     (strb),
    .status   (status),
    .rowAddr  (rowAddr)
  );

  assign refReq = initDone && status.havePending;
  assign weN    = 1'b1;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter bit RAS_ONLY = 1'b0,
  parameter int T_ACTIVE = 3,
  parameter int ROW_W    = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             refGnt,
  input logic             rasN,
  input logic             casN,
  input logic             driveEn,
  input logic             initDone,
  input logic [ROW_W-1:0] rowAddr
);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)     lowRun <= '0;
    else if (!rasN) lowRun <= lowRun + 1'b1;
    else           lowRun <= '0;
  end

  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowRun == 16'(T_ACTIVE))); // R5

  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    (!RAS_ONLY && $fell(rasN)) |-> !$past(casN)); // R4

  AST_CAS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!RAS_ONLY && !rasN) |-> !casN); // R4

  AST_CAS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    RAS_ONLY |-> casN); // R11

  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> $stable(rowAddr)); // R11

  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && $rose(driveEn)) |-> $past(refGnt)); // R9

  AST_INIT_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> driveEn); // R2

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (rasN && casN)); // R10

endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .RAS_ONLY (RAS_ONLY),
  .T_ACTIVE (T_ACTIVE),
  .ROW_W    (ROW_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .refGnt   (refGnt),
  .rasN     (rasN),
  .casN     (casN),
  .driveEn  (driveEn),
  .initDone (initDone),
  .rowAddr  (rowAddr)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int INIT_WAIT    = 10000;
  localparam int INIT_CYCLES  = 8;
  localparam int REF_INTERVAL = 780;
  localparam int MAX_PENDING  = 4;
  localparam int T_SETUP      = 1;
  localparam int T_ACTIVE     = 3;
  localparam int T_PRE        = 2;
  localparam int CYCLE_LEN    = T_SETUP + T_ACTIVE + T_PRE;
  localparam int ROW_INTERVAL = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGnt = 1'b0;
  logic gntAlways = 1'b1;

  logic refReq, driveEn, rasN, casN, weN, initDone;
  logic [9:0] rowAddr;
  logic refReq2, driveEn2, rasN2, casN2, weN2, initDone2;
  logic [9:0] rowAddr2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_refresh_seq uut (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq),
    .driveEn(driveEn), .rasN(rasN), .casN(casN), .weN(weN),
    .rowAddr(rowAddr), .initDone(initDone)
  );

  dram_refresh_seq #(
    .INIT_WAIT(20), .REF_INTERVAL(ROW_INTERVAL), .MAX_PENDING(2), .RAS_ONLY(1'b1)
  ) uutRow (
    .clk(clk), .rstN(rstN), .refGnt(gntAlways), .refReq(refReq2),
    .driveEn(driveEn2), .rasN(rasN2), .casN(casN2), .weN(weN2),
    .rowAddr(rowAddr2), .initDone(initDone2)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (ok !== 1'b1) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nextPend(input int p, input bit tk, input bit st);
    int n;
    n = p + (tk ? 1 : 0) - (st ? 1 : 0);
    if (n > MAX_PENDING) n = MAX_PENDING;
    return n;
  endfunction

  // ---------------- model and monitor, main instance ----------------
  int  edgeCnt = 0;
  bit  seenFirst = 0;
  bit  pRas = 1, pCas = 1, pDrive = 1, pInit = 0;
  int  clRun = 0, rlRun = 0, rhRun = 0;
  int  mTmr = 0, mPend = 0, oldPend;
  bit  tick, start, mTick = 0;
  int  rasFalls = 0, initFalls = 0;

  always @(posedge clk) if (rstN && !seenFirst) edgeCnt++;

  always @(negedge clk) begin
    if (rstN) begin
      tick = 0;
      if (pInit) begin
        if (mTmr == REF_INTERVAL - 1) begin mTmr = 0; tick = 1; end
        else mTmr++;
      end
      mTick = tick;
      start = pCas && !casN && pInit;
      oldPend = mPend;
      if (start) begin
        check(refGnt, "R9 start without grant", refGnt, 1);
        check(oldPend > 0, "R9 start without request", oldPend, 1);
      end
      if (pInit && !pDrive && refGnt && oldPend > 0)
        check(start, "R9 idle grant must start", start, 1);
      if (pInit && pDrive && !driveEn)
        check(!refGnt || oldPend == 0, "R9 burst ended early", oldPend, 0);
      mPend = nextPend(oldPend, tick, start);
      check(refReq === (initDone && mPend != 0), "R7 refReq", refReq, (initDone && mPend != 0));
      check(weN === 1'b1, "R6 weN", weN, 1);
      check(rowAddr == 0, "R12 rowAddr", rowAddr, 0);
      if (!driveEn) check(rasN && casN, "R10 pins released", {rasN, casN}, 3);
      if (!initDone) check(driveEn, "R2 owns pins during init", driveEn, 1);
      if (pRas && !rasN) begin
        check(!casN && clRun == T_SETUP, "R4 CAS lead", clRun, T_SETUP);
        rasFalls++;
        if (!initDone) initFalls++;
      end
      if (!pRas && rasN) begin
        check(rlRun == T_ACTIVE, "R5 RAS width", rlRun, T_ACTIVE);
        check(casN && clRun == T_SETUP + T_ACTIVE, "R4 CAS hold", clRun, T_SETUP + T_ACTIVE);
      end
      if (pCas && !casN) begin
        if (!seenFirst) begin
          seenFirst = 1;
          check(edgeCnt == INIT_WAIT, "R1 power-up pause", edgeCnt, INIT_WAIT);
        end else if (pDrive) begin
          check(rhRun == T_PRE, "R5 burst precharge", rhRun, T_PRE);
        end else begin
          check(rhRun >= T_PRE, "R5 min precharge", rhRun, T_PRE);
        end
      end
      if (!pInit && initDone) begin
        check(initFalls == INIT_CYCLES, "R2 init cycle count", initFalls, INIT_CYCLES);
        check(rhRun == T_PRE && !driveEn, "R3 initDone timing", rhRun, T_PRE);
      end
      clRun = casN ? 0 : clRun + 1;
      rlRun = rasN ? 0 : rlRun + 1;
      rhRun = rasN ? rhRun + 1 : 0;
      pRas = rasN; pCas = casN; pDrive = driveEn; pInit = initDone;
    end
  end

  // ---------------- monitor, row-addressed instance ----------------
  bit         pRas2 = 1;
  logic [9:0] pRow2 = '0;
  logic [9:0] expRow = '0;
  bit         wrapped = 0;

  always @(negedge clk) begin
    if (rstN) begin
      check(casN2 === 1'b1, "R11 CAS stays high", casN2, 1);
      check(weN2 === 1'b1, "R6 weN row mode", weN2, 1);
      if (pRas2 && !rasN2) begin
        check(rowAddr2 == expRow && rowAddr2 == pRow2, "R11 row at RAS fall", rowAddr2, expRow);
        expRow = expRow + 10'd1;
        if (expRow == 10'd0) wrapped = 1;
      end
      if (!pRas2 && !rasN2)
        check(rowAddr2 == pRow2, "R11 row held", rowAddr2, pRow2);
      pRas2 = rasN2; pRow2 = rowAddr2;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish();
  end

  // ---------------- stimulus ----------------
  initial begin
    int base;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    check(rasN && casN && weN && driveEn, "R1 reset pins", {rasN, casN, weN, driveEn}, 15);
    check(!initDone && !refReq, "R1 reset flags", {initDone, refReq}, 0);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(rasN && casN && driveEn && !initDone, "R1 after release", {rasN, casN, driveEn}, 7);
    for (int i = 0; i < 20000 && !initDone; i++) @(negedge clk);
    check(initDone, "R3 initDone reached", initDone, 1);

    // directed: fill the queue, then drain it inside one period
    #1 refGnt = 1'b0;
    repeat ((MAX_PENDING + 2) * REF_INTERVAL) @(negedge clk);
    do begin @(negedge clk); #1; end while (!mTick);
    check(refReq, "R8 request pending when full", refReq, 1);
    base = rasFalls;
    refGnt = 1'b1;
    repeat (CYCLE_LEN * MAX_PENDING + 15) @(negedge clk);
    #1 refGnt = 1'b0;
    check(rasFalls - base == MAX_PENDING, "R8 drained count", rasFalls - base, MAX_PENDING);
    check(!refReq, "R7 queue empty after drain", refReq, 0);

    // directed: permanent grant, each tick served at once
    refGnt = 1'b1;
    repeat (3 * REF_INTERVAL) @(negedge clk);

    // random grant per cycle
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      refGnt = 1'($urandom % 2);
    end

    // random long grant phases
    for (int s = 0; s < 25; s++) begin
      @(negedge clk); #1;
      refGnt = 1'($urandom % 2);
      repeat (1 + ($urandom % 1500)) @(negedge clk);
    end

    #1 refGnt = 1'b0;
    repeat (20) @(negedge clk);
    check(wrapped, "R11 row counter wrap", wrapped, 1);
    finish();
  end

endmodule